// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port that sits on a simple 32-bit register bus. Software sets each pin's direction and output value, and reads back the pad levels after a two-flop synchronizer. Each pin can also raise an interrupt. A per-pin 2-bit mode selects one of four triggers: low level, high level, rising edge or falling edge.

A detected condition sets a sticky status bit, whether or not the pin is enabled. Software clears a status bit by writing a 1 to it. A separate enable (mask) register decides which status bits reach the single port interrupt line. Pins 0 to 15 keep their trigger modes in one configuration word and pins 16 to 31 in a second word.

The bus is a single-cycle write strobe with a combinational read. Word selection uses address bits [4:2]. Address bits [1:0] are ignored.

Top module: `gpio_irq_port`

## Requirements
- R1: The word at byte offset 0x00 is the output data, 0x04 the direction, 0x08 the synchronized pad levels (read only), 0x0C the trigger modes of pins 0-15, 0x10 the trigger modes of pins 16-31, 0x14 the interrupt enable and 0x18 the interrupt status. Address bits [1:0] are ignored, and any other word reads as zero.
- R2: After reset, the data, direction, both trigger words and the enable register read zero, `pad_oe` and `pad_out` are zero, and `irq` is low.
- R3: A write to the data word drives `pad_out` from the next cycle on. A direction bit of 1 asserts the matching `pad_oe` bit, which makes that pin an output.
- R4: The pad word returns `pad_in` through a two-flop synchronizer. A change on `pad_in` is not visible after one rising clock edge and is visible after two.
- R5: Pin p's trigger mode sits at bits [2*(p mod 16)+1 : 2*(p mod 16)] of its configuration word. Mode 0 triggers on a low level, 1 on a high level, 2 on a rising edge and 3 on a falling edge.
- R6: A level trigger keeps its status bit set while the level holds, so the bit sets again after a clear. If the pin leaves the triggering level and the bit is then cleared, it stays clear.
- R7: An edge trigger sets its status bit once for a matching transition of the synchronized level. The opposite transition, or no transition, leaves the bit clear.
- R8: Writing a 1 to a status bit clears it. Writing a 0 leaves that bit unchanged.
- R9: If a trigger condition and a clear of the same status bit occur in the same cycle, the bit stays set.
- R10: Status bits set from their trigger conditions even when the pin's enable bit is 0.
- R11: `irq` is high exactly when some pin has both its status bit and its enable bit set. It follows an enable or status write from the cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 5 | Byte address; bits [4:2] select the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| pad_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Output values to the pads |
| pad_oe | output | 32 | Output enables to the pads, 1 = drive |
| irq | output | 1 | Combined port interrupt |

## Verification
The hardest case to reach from the ports is a clear that lands in the same cycle as an active detection. It only shows up for one cycle before the sticky bit would set again anyway. The bench holds a pin at its triggering high level and issues the clear. It then reads the status word in the very next cycle, so a design where the clear wins would show a zero there. Edge detection is exercised through a table of pin, mode and level transitions spread over both configuration words. Each row first settles the pin and clears its bit, so that only the transition under test can set it.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int PINS = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic            irq
);
  localparam int HALF = PINS / 2;
  localparam int WW   = AW - 2;
  localparam logic [WW-1:0] W_DATA = WW'(0);
  localparam logic [WW-1:0] W_DIR  = WW'(1);
  localparam logic [WW-1:0] W_PAD  = WW'(2);
  localparam logic [WW-1:0] W_CFGL = WW'(3);
  localparam logic [WW-1:0] W_CFGH = WW'(4);
  localparam logic [WW-1:0] W_EN   = WW'(5);
  localparam logic [WW-1:0] W_STAT = WW'(6);

  logic [PINS-1:0] out_q, dir_q, en_q, flag_q;
  logic [2*HALF-1:0] trig_lo_q, trig_hi_q;
  logic [PINS-1:0] s1, s2, s3, hit, clr;
  logic [WW-1:0] widx;
  logic [1:0] unused_lsb;

  assign widx       = addr[AW-1:2];
  assign unused_lsb = addr[1:0];
  assign clr        = (wr_en && widx == W_STAT) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= pad_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic [1:0] mode;
    if (p < HALF) begin : g_lo
      assign mode = trig_lo_q[2*p +: 2];
    end else begin : g_hi
      assign mode = trig_hi_q[2*(p-HALF) +: 2];
    end
    assign hit[p] = (mode == 2'd0) ? ~s2[p] :
                    (mode == 2'd1) ?  s2[p] :
                    (mode == 2'd2) ? (s2[p] & ~s3[p]) :
                                     (~s2[p] & s3[p]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q     <= '0;
      dir_q     <= '0;
      en_q      <= '0;
      trig_lo_q <= '0;
      trig_hi_q <= '0;
      flag_q    <= '0;
    end else begin
      if (wr_en) begin
        case (widx)
          W_DATA:  out_q     <= wdata;
          W_DIR:   dir_q     <= wdata;
          W_CFGL:  trig_lo_q <= wdata[2*HALF-1:0];
          W_CFGH:  trig_hi_q <= wdata[2*HALF-1:0];
          W_EN:    en_q      <= wdata;
          default: ;
        endcase
      end
      flag_q <= (flag_q & ~clr) | hit;
    end
  end

  always_comb begin
    case (widx)
      W_DATA:  rdata = out_q;
      W_DIR:   rdata = dir_q;
      W_PAD:   rdata = s2;
      W_CFGL:  rdata = PINS'(trig_lo_q);
      W_CFGH:  rdata = PINS'(trig_hi_q);
      W_EN:    rdata = en_q;
      W_STAT:  rdata = flag_q;
      default: rdata = '0;
    endcase
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
  assign irq     = |(flag_q & en_q);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int PINS = 32,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [PINS-1:0] wdata,
  input logic [PINS-1:0] pad_out,
  input logic [PINS-1:0] pad_oe,
  input logic            irq,
  input logic [PINS-1:0] en_q,
  input logic [PINS-1:0] flag_q
);
  localparam int WW = AW - 2;

  p_data_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[AW-1:2] == WW'(0)) |=> pad_out == $past(wdata));

  p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[AW-1:2] == WW'(1)) |=> pad_oe == $past(wdata));

  p_zero_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[AW-1:2] == WW'(6) && wdata == '0)
      |=> (flag_q & $past(flag_q)) == $past(flag_q));

  p_clear_or_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr[AW-1:2] == WW'(6)) |=> (flag_q & $past(flag_q)) == $past(flag_q));

  p_masked_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  p_en_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[AW-1:2] == WW'(5)) |=> en_q == $past(wdata));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.PINS(PINS), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq), .en_q(en_q), .flag_q(flag_q)
);

// File: tb/test_gpio_irq_port.sv
`timescale 1ns/1ps
module test_gpio_irq_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pad_out, pad_oe;
  logic [31:0] pad_in = '0;
  logic irq;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_port i_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // pin[9:5] mode[4:3] initial level[2] final level[1] expected status[0]
  localparam logic [9:0] VEC [10] = '{
    {5'd3,  2'd0, 1'b1, 1'b0, 1'b1},
    {5'd20, 2'd0, 1'b1, 1'b1, 1'b0},
    {5'd15, 2'd1, 1'b0, 1'b1, 1'b1},
    {5'd16, 2'd1, 1'b0, 1'b0, 1'b0},
    {5'd31, 2'd2, 1'b0, 1'b1, 1'b1},
    {5'd0,  2'd2, 1'b1, 1'b0, 1'b0},
    {5'd12, 2'd2, 1'b1, 1'b1, 1'b0},
    {5'd27, 2'd3, 1'b1, 1'b0, 1'b1},
    {5'd8,  2'd3, 1'b0, 1'b1, 1'b0},
    {5'd18, 2'd3, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    addr = a;
    #0.1;
    v = rdata;
  endtask

  task automatic set_mode(input int pin, input logic [1:0] m);
    logic [31:0] v;
    logic [4:0] a;
    a = (pin < 16) ? 5'h0C : 5'h10;
    rd(a, v);
    v[2*(pin%16) +: 2] = m;
    wr(a, v);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd(5'h00, v); chk("R2 data", v, 32'h0);
    rd(5'h04, v); chk("R2 dir", v, 32'h0);
    rd(5'h0C, v); chk("R2 cfg low", v, 32'h0);
    rd(5'h10, v); chk("R2 cfg high", v, 32'h0);
    rd(5'h14, v); chk("R2 enable", v, 32'h0);
    chk("R2 pad_oe", pad_oe, 32'h0);
    chk("R2 pad_out", pad_out, 32'h0);
    chk("R2 irq", {31'h0, irq}, 32'h0);

    // R3 data and direction
    wr(5'h00, 32'hA5A5_0F0F);
    chk("R3 pad_out", pad_out, 32'hA5A5_0F0F);
    rd(5'h00, v); chk("R1 data readback", v, 32'hA5A5_0F0F);
    wr(5'h04, 32'hFFFF_0000);
    chk("R3 pad_oe", pad_oe, 32'hFFFF_0000);
    rd(5'h07, v); chk("R1 low address bits ignored", v, 32'hFFFF_0000);
    rd(5'h1C, v); chk("R1 unmapped word", v, 32'h0);

    // R4 synchronizer latency
    pad_in = 32'h1234_5678;
    @(negedge clk);
    rd(5'h08, v); chk("R4 pad after one edge", v, 32'h0);
    @(negedge clk);
    rd(5'h08, v); chk("R4 pad after two edges", v, 32'h1234_5678);
    pad_in = '0;
    settle();

    // R5 R6 R7 trigger table
    for (int k = 0; k < 10; k++) begin
      int pin;
      logic [1:0] m;
      pin = int'(VEC[k][9:5]);
      m = VEC[k][4:3];
      set_mode(pin, m);
      pad_in[pin] = VEC[k][2];
      settle();
      wr(5'h18, 32'h1 << pin);
      pad_in[pin] = VEC[k][1];
      settle();
      rd(5'h18, v);
      chk(m < 2 ? "R5 R6 level table" : "R5 R7 edge table",
          {31'h0, v[pin]}, {31'h0, VEC[k][0]});
      pad_in[pin] = 1'b0;
      settle();
    end

    // R8 write one to clear
    set_mode(9, 2'd2);
    pad_in[9] = 1'b1;
    settle();
    rd(5'h18, v); chk("R7 rising sets", {31'h0, v[9]}, 32'h1);
    wr(5'h18, 32'h0);
    rd(5'h18, v); chk("R8 zero write keeps", {31'h0, v[9]}, 32'h1);
    wr(5'h18, ~(32'h1 << 9));
    rd(5'h18, v); chk("R8 other bits do not clear", {31'h0, v[9]}, 32'h1);
    wr(5'h18, 32'h1 << 9);
    rd(5'h18, v); chk("R8 one clears", {31'h0, v[9]}, 32'h0);

    // R9 detection beats clear in the same cycle
    set_mode(22, 2'd1);
    pad_in[22] = 1'b1;
    settle();
    wr(5'h18, 32'h1 << 22);
    rd(5'h18, v); chk("R9 set wins", {31'h0, v[22]}, 32'h1);

    // R10 R11 masking
    pad_in[9] = 1'b0;
    settle();
    wr(5'h18, 32'h1 << 9);
    pad_in[9] = 1'b1;
    settle();
    rd(5'h18, v); chk("R10 status while masked", {31'h0, v[9]}, 32'h1);
    chk("R11 irq masked", {31'h0, irq}, 32'h0);
    wr(5'h14, 32'h1 << 9);
    chk("R11 irq after enable", {31'h0, irq}, 32'h1);
    wr(5'h18, 32'h1 << 9);
    chk("R11 irq after clear", {31'h0, irq}, 32'h0);
    wr(5'h14, 32'h1 << 22);
    chk("R11 irq level pin", {31'h0, irq}, 32'h1);
    wr(5'h18, 32'h1 << 22);
    chk("R9 irq held by level", {31'h0, irq}, 32'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule